// File: doc/BRIEF.md
# Dual-Loop Mode and Status Controller

This block sits behind the control latches of a frequency synthesizer that runs two phase-locked loops. Loop 1 is index 0 and loop 2 is index 1. When the latch-enable strobe rises, the block loads a 3-bit mode field and the loop-1 charge-pump gain bit. From those two values it drives one shared status pin, a counter-reset strobe for each loop, and a charge-pump enable for each loop.

The shared pin has several uses, picked by the mode:
- **Lock status.** The pin sits high while the selected loop, or both loops, are locked. It drops low while the phase detector is correcting.
- **Reset indicator.** The pin shows that a counter-reset mode is active.
- **Fast-lock switch.** The pin is held low to ground a second damping resistor while the gain bit is set.

Lock flags and the up/down pulses of each phase detector enter as synchronous digital inputs.

Top module: `dual_loop_status_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released until the first mode is loaded, status_o is 0, cnt_rst_o is 2'b00 and cp_en_o is 2'b11.
- R2: mode_i and gain_i are captured only on a clock edge where le_i is 1 and was 0 at the previous edge. The outputs reflect the captured values one clock after that edge. Holding le_i high, or changing mode_i while le_i is low, does not reload them.
- R3: Mode code 1 selects loop-1 lock status. status_o is lock_i[0] AND NOT act[0], where act[0] is the registered OR of up_i[0] and dn_i[0]. Activity on loop 2 has no effect in this mode.
- R4: Mode code 2 selects loop-2 lock status. It behaves as R3, but uses index 1.
- R5: Mode code 3 selects combined lock status. status_o is 1 only when both lock_i bits are 1 and neither loop shows activity.
- R6: Each low-going lock pulse lasts at least STRETCH reference clocks (default 1). A one-cycle up or down pulse at an edge gives exactly one low cycle at the next edge.
- R7: Mode code 4 is the loop-1 counter reset. cnt_rst_o is 2'b01, cp_en_o is 2'b10 and status_o is 1.
- R8: Mode code 5 is the loop-2 counter reset. cnt_rst_o is 2'b10, cp_en_o is 2'b01 and status_o is 1.
- R9: Mode code 6 resets both loops. cnt_rst_o is 2'b11, cp_en_o is 2'b00 and status_o is 1. When this mode is left, both resets release in the same cycle, so each loop's R and AB counters restart together.
- R10: Mode codes 0 and 7 are unused. status_o is a static 0 and no reset is asserted.
- R11: While the captured gain bit is 1, status_o is 0 in every mode (fast-lock). The reset and enable outputs still follow the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| le_i | input | 1 | Latch-enable strobe; rising edge loads the mode and the gain bit |
| mode_i | input | 3 | Mode field, sampled on the latch-enable rise |
| gain_i | input | 1 | Loop-1 charge-pump gain bit, sampled on the latch-enable rise |
| lock_i | input | 2 | Lock flag per loop |
| up_i | input | 2 | Phase-detector up pulse per loop |
| dn_i | input | 2 | Phase-detector down pulse per loop |
| status_o | output | 1 | Shared status / fast-lock pin |
| cnt_rst_o | output | 2 | Per-loop hold of the R and AB counters |
| cp_en_o | output | 2 | Per-loop charge-pump enable (0 = tri-state) |

## Verification
The assertions check four things on every cycle:
- the output decode of each captured mode, covering the reset modes, the unused codes and the lock-mode low condition;
- the fast-lock override;
- that the reset outputs do not move without a latch-enable rise;
- that the reset and enable outputs are never both active for the same loop.

Only the bench scenarios can show the following:
- the exact pulse timing and width on the pin;
- that loop-2 activity is ignored in loop-1 mode;
- that a held latch-enable or a mode change while latch-enable is low causes no reload;
- that both resets release in the same cycle.

// File: rtl/dlmc_pkg.sv
package dlmc_pkg;
  localparam int MODE_W = 3;
  localparam int LOOPS  = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_IDLE      = 3'd0,
    MD_LOCK1     = 3'd1,
    MD_LOCK2     = 3'd2,
    MD_LOCK_BOTH = 3'd3,
    MD_RST1      = 3'd4,
    MD_RST2      = 3'd5,
    MD_RST_BOTH  = 3'd6,
    MD_SPARE     = 3'd7
  } mode_e;
endpackage

// File: rtl/dlmc_mode_latch.sv
module dlmc_mode_latch
  import dlmc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              gain_i,
  output mode_e             mode_o,
  output logic              gain_o
);
  logic le_q;
  logic le_rise;

  assign le_rise = le_i & ~le_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_q   <= 1'b0;
      mode_o <= MD_IDLE;
      gain_o <= 1'b0;
    end else begin
      le_q <= le_i;
      if (le_rise) begin
        mode_o <= mode_e'(mode_i);
        gain_o <= gain_i;
      end
    end
  end
endmodule

// File: rtl/dlmc_act_stretch.sv
module dlmc_act_stretch #(
  parameter int STRETCH = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  output logic act_o
);
  localparam int CW = (STRETCH > 1) ? $clog2(STRETCH) : 1;

  logic          pulse;
  logic [CW-1:0] hold_q;

  assign pulse = up_i | dn_i;

  // act_o stays high for STRETCH cycles after the last pulse cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o  <= 1'b0;
      hold_q <= '0;
    end else begin
      act_o <= pulse | (hold_q != '0);
      if (pulse)               hold_q <= CW'(STRETCH - 1);
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end
  end
endmodule

// File: rtl/dlmc_out_decode.sv
module dlmc_out_decode
  import dlmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             gain_i,
  input  logic [LOOPS-1:0] lock_i,
  input  logic [LOOPS-1:0] act_i,
  output logic             status_o,
  output logic [LOOPS-1:0] cnt_rst_o,
  output logic [LOOPS-1:0] cp_en_o
);
  logic             status_d;
  logic [LOOPS-1:0] rst_d;

  always_comb begin
    status_d = 1'b0;
    rst_d    = '0;
    unique case (mode_i)
      MD_LOCK1:     status_d = lock_i[0] & ~act_i[0];
      MD_LOCK2:     status_d = lock_i[1] & ~act_i[1];
      MD_LOCK_BOTH: status_d = (&lock_i) & ~(|act_i);
      MD_RST1:      begin rst_d = 2'b01; status_d = 1'b1; end
      MD_RST2:      begin rst_d = 2'b10; status_d = 1'b1; end
      MD_RST_BOTH:  begin rst_d = 2'b11; status_d = 1'b1; end
      default:      status_d = 1'b0;
    endcase
    if (gain_i) status_d = 1'b0;  // fast-lock grounds the damping resistor
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o  <= 1'b0;
      cnt_rst_o <= '0;
      cp_en_o   <= '1;
    end else begin
      status_o  <= status_d;
      cnt_rst_o <= rst_d;
      cp_en_o   <= ~rst_d;
    end
  end
endmodule

// File: rtl/dual_loop_status_ctrl.sv
module dual_loop_status_ctrl
  import dlmc_pkg::*;
#(
  parameter int STRETCH = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              gain_i,
  input  logic [LOOPS-1:0]  lock_i,
  input  logic [LOOPS-1:0]  up_i,
  input  logic [LOOPS-1:0]  dn_i,
  output logic              status_o,
  output logic [LOOPS-1:0]  cnt_rst_o,
  output logic [LOOPS-1:0]  cp_en_o
);
  mode_e            mode_q;
  logic             gain_q;
  logic [LOOPS-1:0] act;

  dlmc_mode_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .mode_i (mode_i),
    .gain_i (gain_i),
    .mode_o (mode_q),
    .gain_o (gain_q)
  );

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    dlmc_act_stretch #(.STRETCH(STRETCH)) u_stretch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .up_i   (up_i[g]),
      .dn_i   (dn_i[g]),
      .act_o  (act[g])
    );
  end

  dlmc_out_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_q),
    .gain_i    (gain_q),
    .lock_i    (lock_i),
    .act_i     (act),
    .status_o  (status_o),
    .cnt_rst_o (cnt_rst_o),
    .cp_en_o   (cp_en_o)
  );
endmodule

// File: rtl/dlmc_checker.sv
module dlmc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       le_i,
  input logic [2:0] mode_q,
  input logic       gain_q,
  input logic [1:0] lock_i,
  input logic       status_o,
  input logic [1:0] cnt_rst_o,
  input logic [1:0] cp_en_o
);
  a_r11_fastlock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(gain_q) |-> !status_o);

  a_r10_unused_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == 3'd0 || $past(mode_q) == 3'd7) |-> (!status_o && cnt_rst_o == 2'b00));

  a_r7_rst_loop1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_q) == 3'd4 |-> (cnt_rst_o == 2'b01 && cp_en_o == 2'b10));

  a_r8_rst_loop2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_q) == 3'd5 |-> (cnt_rst_o == 2'b10 && cp_en_o == 2'b01));

  a_r9_rst_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_q) == 3'd6 |-> (cnt_rst_o == 2'b11 && cp_en_o == 2'b00));

  a_r3_unlock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == 3'd1 && !$past(lock_i[0])) |-> !status_o);

  a_r5_combined_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == 3'd3 && !(&$past(lock_i))) |-> !status_o);

  a_r2_no_le_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(le_i) && !$past(le_i, 2)) |-> $stable(cnt_rst_o));

  a_r9_rst_cp_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_o & cp_en_o) == 2'b00);
endmodule

bind dual_loop_status_ctrl dlmc_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .le_i      (le_i),
  .mode_q    (mode_q),
  .gain_q    (gain_q),
  .lock_i    (lock_i),
  .status_o  (status_o),
  .cnt_rst_o (cnt_rst_o),
  .cp_en_o   (cp_en_o)
);

// File: tb/sim_dual_loop_status_ctrl.sv
`timescale 1ns/1ps
module sim_dual_loop_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       le = 1'b0;
  logic [2:0] mode = '0;
  logic       gain = 1'b0;
  logic [1:0] lock = '0;
  logic [1:0] up = '0;
  logic [1:0] dn = '0;
  logic       status;
  logic [1:0] cnt_rst;
  logic [1:0] cp_en;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_loop_status_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .le_i(le), .mode_i(mode), .gain_i(gain),
    .lock_i(lock), .up_i(up), .dn_i(dn),
    .status_o(status), .cnt_rst_o(cnt_rst), .cp_en_o(cp_en)
  );

  typedef struct packed {
    logic [2:0] md;
    logic       gn;
    logic [1:0] lk;
    logic       st;
    logic [1:0] rs;
    logic [1:0] ce;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b0, 2'b01, 1'b1, 2'b00, 2'b11, 4'd3},   // R3
    '{3'd1, 1'b0, 2'b10, 1'b0, 2'b00, 2'b11, 4'd3},   // R3
    '{3'd2, 1'b0, 2'b10, 1'b1, 2'b00, 2'b11, 4'd4},   // R4
    '{3'd2, 1'b0, 2'b01, 1'b0, 2'b00, 2'b11, 4'd4},   // R4
    '{3'd3, 1'b0, 2'b11, 1'b1, 2'b00, 2'b11, 4'd5},   // R5
    '{3'd3, 1'b0, 2'b01, 1'b0, 2'b00, 2'b11, 4'd5},   // R5
    '{3'd3, 1'b0, 2'b10, 1'b0, 2'b00, 2'b11, 4'd5},   // R5
    '{3'd4, 1'b0, 2'b00, 1'b1, 2'b01, 2'b10, 4'd7},   // R7
    '{3'd5, 1'b0, 2'b00, 1'b1, 2'b10, 2'b01, 4'd8},   // R8
    '{3'd6, 1'b0, 2'b11, 1'b1, 2'b11, 2'b00, 4'd9},   // R9
    '{3'd0, 1'b0, 2'b11, 1'b0, 2'b00, 2'b11, 4'd10},  // R10
    '{3'd7, 1'b0, 2'b11, 1'b0, 2'b00, 2'b11, 4'd10},  // R10
    '{3'd1, 1'b1, 2'b11, 1'b0, 2'b00, 2'b11, 4'd11},  // R11
    '{3'd4, 1'b1, 2'b00, 1'b0, 2'b01, 2'b10, 4'd11}   // R11
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic st, input logic [1:0] rs,
                         input logic [1:0] ce);
    chk(req, {status, cnt_rst, cp_en}, {st, rs, ce});
  endtask

  // drive at negedge; on return the outputs reflect the new mode
  task automatic load(input logic [2:0] m, input logic g);
    mode = m; gain = g; le = 1'b1;
    @(negedge clk);
    le = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 1'b0, 2'b00, 2'b11);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R1 after reset", 1'b0, 2'b00, 2'b11);

    for (int i = 0; i < NV; i++) begin
      lock = VEC[i].lk;
      load(VEC[i].md, VEC[i].gn);
      @(negedge clk);
      chk_all($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].st, VEC[i].rs, VEC[i].ce);
    end

    // R2: one-cycle latency after capture edge
    lock = 2'b11;
    load(3'd0, 1'b0);
    mode = 3'd4; le = 1'b1;
    @(negedge clk);
    chk("R2 before effect", cnt_rst, 2'b00);
    @(negedge clk);
    chk("R2 after effect", cnt_rst, 2'b01);
    // R2: le held high, mode changes, no reload
    mode = 3'd5;
    repeat (3) @(negedge clk);
    chk("R2 held le", cnt_rst, 2'b01);
    le = 1'b0;
    mode = 3'd6;
    repeat (3) @(negedge clk);
    chk("R2 le low", cnt_rst, 2'b01);

    // R9: both resets release together
    load(3'd6, 1'b0);
    chk("R9 both held", cnt_rst, 2'b11);
    mode = 3'd1; le = 1'b1;
    @(negedge clk);
    le = 1'b0;
    chk("R9 still held", cnt_rst, 2'b11);
    @(negedge clk);
    chk("R9 released together", {cnt_rst, cp_en}, {2'b00, 2'b11});

    // R6 / R3: one-cycle up pulse on loop 1 gives one low cycle
    chk("R3 locked high", status, 1'b1);
    up[0] = 1'b1;
    @(negedge clk);
    up[0] = 1'b0;
    chk("R6 not yet low", status, 1'b1);
    @(negedge clk);
    chk("R6 low pulse", status, 1'b0);
    @(negedge clk);
    chk("R6 pulse ends", status, 1'b1);

    // R3: loop-2 activity ignored in loop-1 mode
    dn[1] = 1'b1;
    @(negedge clk);
    dn[1] = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R3 loop2 ignored", status, 1'b1);
    end

    // R5: loop-2 down pulse pulls combined status low
    load(3'd3, 1'b0);
    chk("R5 both locked", status, 1'b1);
    dn[1] = 1'b1;
    @(negedge clk);
    dn[1] = 1'b0;
    @(negedge clk);
    chk("R5 activity low", status, 1'b0);
    @(negedge clk);
    chk("R5 recovers", status, 1'b1);

    // R4: loop-2 up held two cycles -> two low cycles
    load(3'd2, 1'b0);
    up[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    up[1] = 1'b0;
    chk("R4 low 1", status, 1'b0);
    @(negedge clk);
    chk("R4 low 2", status, 1'b0);
    @(negedge clk);
    chk("R4 high", status, 1'b1);

    // R11: fast-lock cleared by reload
    load(3'd2, 1'b1);
    chk("R11 fastlock", status, 1'b0);
    load(3'd2, 1'b0);
    @(negedge clk);
    chk("R11 fastlock off", status, 1'b1);

    finish_run();
  end
endmodule